// File: doc/BRIEF.md
# Serial channel status flag register

This block holds the five sticky status flags of an asynchronous serial channel as one byte that the CPU can read: transmit buffer empty, receive buffer full, overrun, framing error and parity error. The transmit and receive datapaths report their events to it as single-cycle strobes. A transfer controller that moves data without the CPU can also clear the two data flags as a side effect of its own accesses. The shifters, baud timing and data registers are outside the block, and only their handshake strobes come in.

Software clears a flag with a two-step handshake. It first reads the byte while the flag is 1, which arms that bit. It then writes a byte with a 0 in that position. Writing 1 to a bit never changes it. A hardware event that sets a flag wins over a clear in the same cycle. A hardware clear cancels a pending arm, so a later write cannot clear a flag the CPU never saw set. The standby input holds the flags in their idle state.

Top module: `sci_status_reg`

## Requirements
- R1: The read byte holds transmit-empty at bit 7, receive-full at bit 6, overrun at bit 5, framing error at bit 4 and parity error at bit 3. Bits 2 to 0 always read 1, and writes to them do nothing.
- R2: After synchronous active-low reset the byte reads 0x87: transmit-empty is 1 and the other four flags are 0.
- R3: A write with 1 in a flag bit leaves that flag unchanged.
- R4: A write with 0 in a flag bit clears that flag only when the latest CPU read saw the bit as 1 and no write has occurred since that read. Any write disarms all bits.
- R5: Transmit-empty is set one cycle after a tx_load strobe or a tx_enable_clr strobe.
- R6: Transmit-empty is cleared one cycle after a dma_tx_write strobe.
- R7: Receive-full is set by an rx_done strobe that has neither error input high. It is cleared by a dma_rx_read strobe.
- R8: Overrun is set by an rx_done strobe that arrives while receive-full is already 1.
- R9: Framing error is set by rx_done together with rx_frame_err. Parity error is set by rx_done together with rx_parity_err.
- R10: While standby is high the byte is forced to 0x87, this overrides every other input, and all arms are cancelled.
- R11: A hardware clear of a flag cancels its arm, so a later CPU write of 0 does not clear that flag once it is set again.
- R12: When a hardware set and a clear, from the CPU or the transfer controller, hit the same flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby level, forces idle flag state |
| cpu_rd | input | 1 | CPU read strobe, arms the bits that read 1 |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data, 0 requests a clear |
| cpu_rdata | output | 8 | Current flag byte |
| tx_load | input | 1 | Transmit data moved into the shifter |
| tx_enable_clr | input | 1 | Transmitter enable was cleared |
| dma_tx_write | input | 1 | Transfer controller wrote transmit data |
| rx_done | input | 1 | A received character completed |
| rx_frame_err | input | 1 | Stop bit of that character was 0 |
| rx_parity_err | input | 1 | Parity of that character mismatched |
| dma_rx_read | input | 1 | Transfer controller read receive data |

## Verification
The clear handshake is tried in several forms. One write has no prior read, one write of all ones follows a read, one read saw the bit as 0 before the bit was set, and one write follows a hardware clear. Together these separate a correct arm from a write-only clear, a clear on any 0 bit, and a stale arm. Receive strobes are given clean, while receive-full is already high, and with each error input, which tells the full flag, overrun and the two error flags apart. Same-cycle set-and-clear cases and standby with pending arms show which input takes priority.

// File: rtl/sci_status_pkg.sv
// Shared constants and types for the serial status flag register.
// Flag index 0 is the most significant flag bit of the byte.
package sci_status_pkg;
    localparam int NUM_FLAGS = 5;
    localparam int FL_TXE    = 0;
    localparam int FL_RXF    = 1;
    localparam int FL_OVR    = 2;
    localparam int FL_FRM    = 3;
    localparam int FL_PAR    = 4;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    // Value after reset and while in standby: only transmit-empty is set.
    localparam flag_vec_t IDLE_FLAGS = flag_vec_t'(1) << FL_TXE;
endpackage

// File: rtl/sci_flag_cell.sv
// One sticky status flag with its CPU read-arm bit.
// Assumes the strobes are single-cycle and synchronous to clk.
// Priority: standby, then a hardware set, then the hardware and CPU clears.
module sci_flag_cell #(
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic wr_bit,
    output logic flag_q,
    output logic armed_q
);
    logic flag_d;
    logic armed_d;
    logic cpu_clr;

    // Next-state logic for the flag and its arm.
    always_comb begin
        cpu_clr = cpu_wr && !wr_bit && armed_q;
        if (standby) begin
            flag_d  = IDLE_VAL;
            armed_d = 1'b0;
        end else begin
            flag_d = hw_set || (flag_q && !hw_clr && !cpu_clr);
            if (hw_clr)      armed_d = 1'b0;
            else if (cpu_rd) armed_d = flag_q;
            else if (cpu_wr) armed_d = 1'b0;
            else             armed_d = armed_q;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= IDLE_VAL;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/sci_event_map.sv
// Maps datapath and transfer-controller strobes onto per-flag set and
// clear requests. Overrun is judged from the current receive-full flag.
module sci_event_map
    import sci_status_pkg::*;
(
    input  logic      tx_load,
    input  logic      tx_enable_clr,
    input  logic      dma_tx_write,
    input  logic      rx_done,
    input  logic      rx_frame_err,
    input  logic      rx_parity_err,
    input  logic      dma_rx_read,
    input  logic      rxf_now,
    output flag_vec_t set_vec,
    output flag_vec_t clr_vec
);
    logic rx_clean;

    // Decode events into set and clear vectors.
    always_comb begin
        rx_clean        = rx_done && !rx_frame_err && !rx_parity_err;
        set_vec         = '0;
        clr_vec         = '0;
        set_vec[FL_TXE] = tx_load || tx_enable_clr;
        clr_vec[FL_TXE] = dma_tx_write;
        set_vec[FL_RXF] = rx_clean;
        clr_vec[FL_RXF] = dma_rx_read;
        set_vec[FL_OVR] = rx_done && rxf_now;
        set_vec[FL_FRM] = rx_done && rx_frame_err;
        set_vec[FL_PAR] = rx_done && rx_parity_err;
    end
endmodule

// File: rtl/sci_readback.sv
// Packs the flag vector into the CPU byte; unused low bits read as 1.
// Assumes REG_W is at least NUM_FLAGS.
module sci_readback
    import sci_status_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  flag_vec_t         flags,
    output logic [REG_W-1:0]  rdata
);
    localparam int LOW_W = REG_W - NUM_FLAGS;

    genvar gi;
    // Flag bits, highest bit first.
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
            assign rdata[REG_W-1-gi] = flags[gi];
        end
        if (LOW_W > 0) begin : g_fill
            assign rdata[LOW_W-1:0] = '1;
        end
    endgenerate
endmodule

// File: rtl/sci_status_reg.sv
// Serial channel status flag register: five sticky flags, cleared by the
// CPU through a read-1-then-write-0 handshake. Assumes single-cycle strobes.
module sci_status_reg
    import sci_status_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             tx_load,
    input  logic             tx_enable_clr,
    input  logic             dma_tx_write,
    input  logic             rx_done,
    input  logic             rx_frame_err,
    input  logic             rx_parity_err,
    input  logic             dma_rx_read
);
    flag_vec_t flags_q;
    flag_vec_t armed_vec;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;

    sci_event_map u_map (
        .tx_load       (tx_load),
        .tx_enable_clr (tx_enable_clr),
        .dma_tx_write  (dma_tx_write),
        .rx_done       (rx_done),
        .rx_frame_err  (rx_frame_err),
        .rx_parity_err (rx_parity_err),
        .dma_rx_read   (dma_rx_read),
        .rxf_now       (flags_q[FL_RXF]),
        .set_vec       (set_vec),
        .clr_vec       (clr_vec)
    );

    genvar gi;
    // One cell per flag; the write bit comes from the matching byte position.
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_cell
            sci_flag_cell #(.IDLE_VAL(IDLE_FLAGS[gi])) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .standby (standby),
                .hw_set  (set_vec[gi]),
                .hw_clr  (clr_vec[gi]),
                .cpu_rd  (cpu_rd),
                .cpu_wr  (cpu_wr),
                .wr_bit  (cpu_wdata[REG_W-1-gi]),
                .flag_q  (flags_q[gi]),
                .armed_q (armed_vec[gi])
            );
        end
    endgenerate

    sci_readback #(.REG_W(REG_W)) u_rb (
        .flags (flags_q),
        .rdata (cpu_rdata)
    );
endmodule

// File: rtl/sci_status_chk.sv
// Property checker for the status register, bound to every instance.
module sci_status_chk
    import sci_status_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby,
    input logic             cpu_rd,
    input logic             cpu_wr,
    input logic [REG_W-1:0] cpu_wdata,
    input logic [REG_W-1:0] cpu_rdata,
    input logic             tx_load,
    input logic             tx_enable_clr,
    input logic             dma_tx_write,
    input logic             rx_done,
    input logic             dma_rx_read,
    input flag_vec_t        armed_vec
);
    localparam int TXB = REG_W - 1 - FL_TXE;
    localparam int RXB = REG_W - 1 - FL_RXF;
    localparam int OVB = REG_W - 1 - FL_OVR;
    logic any_hw;
    assign any_hw = tx_load || tx_enable_clr || dma_tx_write || rx_done || dma_rx_read;

    AST_STBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> cpu_rdata[REG_W-1 -: NUM_FLAGS] == IDLE_FLAGS[0 +: NUM_FLAGS] ||
                    {<<{cpu_rdata[REG_W-1 -: NUM_FLAGS]}} == IDLE_FLAGS); // R10
    AST_WR_ONES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && !standby && !any_hw && (&cpu_wdata)) |=> $stable(cpu_rdata)); // R3
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && cpu_rdata[RXB] && !standby) |=> cpu_rdata[OVB]); // R8
    AST_TXE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !standby) |=> cpu_rdata[TXB]); // R12
    AST_DMA_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_read && !rx_done && !standby) |=> !cpu_rdata[RXB]); // R7
    AST_NO_BLIND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !armed_vec[FL_TXE] && !standby && !dma_tx_write && cpu_rdata[TXB])
        |=> cpu_rdata[TXB]); // R4
endmodule

bind sci_status_reg sci_status_chk #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .standby       (standby),
    .cpu_rd        (cpu_rd),
    .cpu_wr        (cpu_wr),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .tx_load       (tx_load),
    .tx_enable_clr (tx_enable_clr),
    .dma_tx_write  (dma_tx_write),
    .rx_done       (rx_done),
    .dma_rx_read   (dma_rx_read),
    .armed_vec     (armed_vec)
);

// File: tb/sci_status_reg_bench.sv
// Bench: behavioural reference model compared with the read byte every cycle.
module sci_status_reg_bench;
    localparam int CLK_HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'hFF;
    logic [7:0] cpu_rdata;
    logic       tx_load = 1'b0;
    logic       tx_enable_clr = 1'b0;
    logic       dma_tx_write = 1'b0;
    logic       rx_done = 1'b0;
    logic       rx_frame_err = 1'b0;
    logic       rx_parity_err = 1'b0;
    logic       dma_rx_read = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int fl [5];
    int ar [5];

    always #CLK_HALF clk = ~clk;

    sci_status_reg u_sci_status_reg (
        .clk(clk), .rst_n(rst_n), .standby(standby), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tx_load(tx_load), .tx_enable_clr(tx_enable_clr),
        .dma_tx_write(dma_tx_write), .rx_done(rx_done),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .dma_rx_read(dma_rx_read)
    );

    function automatic logic [7:0] model_byte();
        logic [7:0] b = 8'h07;
        for (int i = 0; i < 5; i++) if (fl[i] != 0) b[7-i] = 1'b1;
        return b;
    endfunction

    // Reference behaviour: one clock of the flag rules from the requirements.
    task automatic model_step();
        int nf [5];
        int setr [5];
        int clrr [5];
        if (standby) begin
            for (int i = 0; i < 5; i++) begin nf[i] = 0; ar[i] = 0; end
            nf[0] = 1;
        end else begin
            setr[0] = int'(tx_load | tx_enable_clr);
            clrr[0] = int'(dma_tx_write);
            setr[1] = int'(rx_done & !rx_frame_err & !rx_parity_err);
            clrr[1] = int'(dma_rx_read);
            setr[2] = (rx_done && fl[1] != 0) ? 1 : 0;
            setr[3] = int'(rx_done & rx_frame_err);
            setr[4] = int'(rx_done & rx_parity_err);
            clrr[2] = 0; clrr[3] = 0; clrr[4] = 0;
            for (int i = 0; i < 5; i++) begin
                if (setr[i] != 0) nf[i] = 1;
                else if (clrr[i] != 0) nf[i] = 0;
                else if (cpu_wr && cpu_wdata[7-i] == 1'b0 && ar[i] != 0) nf[i] = 0;
                else nf[i] = fl[i];
                if (clrr[i] != 0) ar[i] = 0;
                else if (cpu_rd) ar[i] = fl[i];
                else if (cpu_wr) ar[i] = 0;
            end
        end
        for (int i = 0; i < 5; i++) fl[i] = nf[i];
    endtask

    task automatic compare(string tag);
        logic [7:0] exp = model_byte();
        checks++;
        if (cpu_rdata !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, cpu_rdata, exp, $time);
        end
    endtask

    // One clock with the inputs as currently driven, then compare and idle.
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        cpu_rd = 0; cpu_wr = 0; cpu_wdata = 8'hFF; tx_load = 0;
        tx_enable_clr = 0; dma_tx_write = 0; rx_done = 0;
        rx_frame_err = 0; rx_parity_err = 0; dma_rx_read = 0;
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin fl[i] = 0; ar[i] = 0; end
        fl[0] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R2");
        tick("R2");
        cpu_wr = 1; cpu_wdata = 8'h00; tick("R4");
        cpu_rd = 1; tick("R4");
        cpu_wr = 1; cpu_wdata = 8'hFF; tick("R3");
        cpu_rd = 1; tick("R4");
        cpu_wr = 1; cpu_wdata = 8'h78; tick("R1");
        cpu_wr = 1; cpu_wdata = 8'h00; tick("R1");
        tx_load = 1; tick("R5");
        dma_tx_write = 1; tick("R6");
        tx_enable_clr = 1; tick("R5");
        rx_done = 1; tick("R7");
        rx_done = 1; tick("R8");
        rx_done = 1; rx_frame_err = 1; tick("R9");
        rx_done = 1; rx_parity_err = 1; tick("R9");
        cpu_rd = 1; tick("R4");
        dma_rx_read = 1; tick("R7");
        rx_done = 1; tick("R11");
        cpu_wr = 1; cpu_wdata = 8'h00; tick("R11");
        cpu_rd = 1; tick("R12");
        cpu_wr = 1; cpu_wdata = 8'h00; rx_done = 1; tick("R12");
        tx_load = 1; dma_tx_write = 1; tick("R12");
        cpu_wr = 1; cpu_wdata = 8'h00; tick("R4");
        cpu_rd = 1; tick("R4");
        cpu_wr = 1; cpu_wdata = 8'h00; tick("R4");
        dma_tx_write = 1; tick("R6");
        cpu_rd = 1; tick("R4");
        tx_load = 1; tick("R5");
        cpu_wr = 1; cpu_wdata = 8'h00; tick("R4");
        rx_done = 1; tick("R7");
        rx_done = 1; rx_frame_err = 1; tick("R9");
        cpu_rd = 1; tick("R10");
        standby = 1; tick("R10");
        standby = 1; rx_done = 1; rx_parity_err = 1; tick("R10");
        standby = 1; dma_tx_write = 1; tick("R10");
        standby = 0; cpu_wr = 1; cpu_wdata = 8'h00; tick("R10");
        tick("R10");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule